// File: doc/BRIEF.md
# Dual-Clock Width-Converting Bus Bridge

This block connects a wide master port to a narrow slave port. The two ports run on unrelated clocks. Three small dual-clock queues separate the two clock domains. The command queue carries the address and the direction. The write queue carries full master words. The return queue carries packed master words back to the master. Each queue has a load strobe and a full flag on the side that writes it, and a request strobe and an empty flag on the side that reads it.

On the master side, a command is accepted with a valid/ready handshake. A command that is accepted and is a write also places its word in the write queue. On the slave side, a small sequencer takes one command at a time and issues it as a burst of narrow beats, least-significant slice first. The slave address steps up by one on each beat. A read collects the returned slices and places one packed word in the return queue. The master drains that queue through a valid/ready response port.

The slave stub accepts a beat with `s_ready`. On a read, it returns the data for the presented address in the same cycle (`s_rdata`). The master width must be a whole multiple of the slave width, and at least twice it.

Top module: `xclk_width_bridge`

## Requirements
- R1: An accepted write of word W at address A produces MW/SW slave write beats in order. Beat i carries address A+i and data W[i*SW +: SW], so the least-significant slice goes first.
- R2: An accepted read at address A produces MW/SW slave read beats at addresses A+i, issued in order. It also produces exactly one master response. Bits [i*SW +: SW] of that response hold the slave data returned on beat i.
- R3: Slave beats appear in the order the commands were accepted. Master responses appear in the order the reads were accepted.
- R4: `m_cmd_ready` is low while the command queue is full, and also while a write is offered with the write queue full. A command offered while ready is low is not taken. With the slave port fully stalled, exactly 2^DEPTH_LOG2 + 1 writes are accepted: one is held by the sequencer and the rest fill the queues.
- R5: `m_rsp_valid` is low whenever the return queue is empty, and a request made then produces no response. While `m_rsp_valid` is high and `m_rsp_ready` is low, `m_rsp_data` holds steady.
- R6: After reset, `m_cmd_ready` is 1, `m_rsp_valid` is 0 and `s_valid` is 0.
- R7: Behaviour is correct when the slave clock is four times slower than the master clock, and also when it is four times faster.
- R8: While `s_valid` is high and `s_ready` is low, `s_addr`, `s_we` and `s_wdata` stay steady.
- R9: Under random stalls on both ports, no command, beat or response is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master-side clock |
| m_rst_n | input | 1 | Master-side asynchronous reset, active low |
| m_cmd_valid | input | 1 | Master offers a command |
| m_cmd_ready | output | 1 | Bridge can take the offered command |
| m_cmd_we | input | 1 | 1 = write, 0 = read |
| m_cmd_addr | input | AW | Start address in slave-beat units |
| m_cmd_wdata | input | MW | Write word |
| m_rsp_valid | output | 1 | A read word is available |
| m_rsp_ready | input | 1 | Master takes the read word |
| m_rsp_data | output | MW | Packed read word |
| s_clk | input | 1 | Slave-side clock |
| s_rst_n | input | 1 | Slave-side asynchronous reset, active low |
| s_valid | output | 1 | A slave beat is presented |
| s_ready | input | 1 | Slave accepts the beat |
| s_we | output | 1 | Beat direction |
| s_addr | output | AW | Beat address |
| s_wdata | output | SW | Beat write slice |
| s_rdata | input | SW | Read slice returned in the accepting cycle |

## Verification
Two pairs of actions can fall in the same cycle:
- In the master domain, a new command can load the command queue on the same edge that the slave side's freeing of an entry arrives through the pointer synchroniser.
- In the two domains, the final read beat can load the return queue while the master pops an older word from it.

The bench provokes the first pair by stalling the slave port until the master sees ready drop. It then releases the stall while the master keeps offering commands. It provokes the second pair with back-to-back reads under random response stalls, at both clock ratios. A scoreboard judges every slave beat and every response against expectations built when each command is accepted, so a dropped, repeated or reordered entry shows up as a miscompare or as a residue in a queue.

// File: rtl/xclk_width_bridge.sv
module xclk_width_bridge_fifo #(
  parameter int W    = 8,
  parameter int LOG2 = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         load,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         req,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int DEPTH = 1 << LOG2;
  localparam logic [LOG2:0] FLIP = (LOG2+1)'(3 << (LOG2-1));

  logic [W-1:0] mem [DEPTH];
  logic [LOG2:0] wbin, wbin_n, wgray, wgray_n, rs1, rs2;
  logic [LOG2:0] rbin, rbin_n, rgray, rgray_n, ws1, ws2;

  assign full    = (wgray == (rs2 ^ FLIP));
  assign empty   = (rgray == ws2);
  assign wbin_n  = wbin + {{LOG2{1'b0}}, (load && !full)};
  assign rbin_n  = rbin + {{LOG2{1'b0}}, (req && !empty)};
  assign wgray_n = wbin_n ^ (wbin_n >> 1);
  assign rgray_n = rbin_n ^ (rbin_n >> 1);
  assign rdata   = mem[rbin[LOG2-1:0]];

  always_ff @(posedge wclk)
    if (load && !full) mem[wbin[LOG2-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rs1 <= '0; rs2 <= '0;
    end else begin
      wbin <= wbin_n; wgray <= wgray_n; rs1 <= rgray; rs2 <= rs1;
    end

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; ws1 <= '0; ws2 <= '0;
    end else begin
      rbin <= rbin_n; rgray <= rgray_n; ws1 <= wgray; ws2 <= ws1;
    end
endmodule

module xclk_width_bridge #(
  parameter int MW         = 32,
  parameter int SW         = 8,
  parameter int AW         = 16,
  parameter int DEPTH_LOG2 = 2
) (
  input  logic          m_clk,
  input  logic          m_rst_n,
  input  logic          m_cmd_valid,
  output logic          m_cmd_ready,
  input  logic          m_cmd_we,
  input  logic [AW-1:0] m_cmd_addr,
  input  logic [MW-1:0] m_cmd_wdata,
  output logic          m_rsp_valid,
  input  logic          m_rsp_ready,
  output logic [MW-1:0] m_rsp_data,
  input  logic          s_clk,
  input  logic          s_rst_n,
  output logic          s_valid,
  input  logic          s_ready,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [SW-1:0] s_wdata,
  input  logic [SW-1:0] s_rdata
);
  localparam int RATIO = MW / SW;
  localparam int BW    = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [BW-1:0] LAST = BW'(RATIO - 1);

  logic          a_full, a_empty, a_req, w_full, w_empty, w_req, r_full, r_load;
  logic [AW:0]   a_out;
  logic [MW-1:0] w_out, r_word;
  logic          acc, start, fire, busy, cur_we;
  logic [BW-1:0] beat;
  logic [AW-1:0] base;
  logic [MW-1:0] wsh;
  logic [MW-SW-1:0] pack;

  assign m_cmd_ready = !a_full && (!m_cmd_we || !w_full);
  assign acc         = m_cmd_valid && m_cmd_ready;

  xclk_width_bridge_fifo #(.W(AW+1), .LOG2(DEPTH_LOG2)) u_cmdq (
    .wclk(m_clk), .wrst_n(m_rst_n), .load(acc), .wdata({m_cmd_we, m_cmd_addr}), .full(a_full),
    .rclk(s_clk), .rrst_n(s_rst_n), .req(a_req), .rdata(a_out), .empty(a_empty));

  xclk_width_bridge_fifo #(.W(MW), .LOG2(DEPTH_LOG2)) u_wrq (
    .wclk(m_clk), .wrst_n(m_rst_n), .load(acc && m_cmd_we), .wdata(m_cmd_wdata), .full(w_full),
    .rclk(s_clk), .rrst_n(s_rst_n), .req(w_req), .rdata(w_out), .empty(w_empty));

  xclk_width_bridge_fifo #(.W(MW), .LOG2(DEPTH_LOG2)) u_rtq (
    .wclk(s_clk), .wrst_n(s_rst_n), .load(r_load), .wdata(r_word), .full(r_full),
    .rclk(m_clk), .rrst_n(m_rst_n), .req(m_rsp_valid && m_rsp_ready), .rdata(m_rsp_data),
    .empty(m_rsp_valid_n));

  logic m_rsp_valid_n;
  assign m_rsp_valid = !m_rsp_valid_n;

  // a read starts only with room in the return queue; only this side fills it
  assign start  = !busy && !a_empty && (a_out[AW] ? !w_empty : !r_full);
  assign a_req  = start;
  assign w_req  = start && a_out[AW];
  assign fire   = busy && s_ready;
  assign r_word = {s_rdata, pack};
  assign r_load = fire && (beat == LAST) && !cur_we;

  assign s_valid = busy;
  assign s_we    = cur_we;
  assign s_addr  = base + AW'(beat);
  assign s_wdata = wsh[SW-1:0];

  always_ff @(posedge s_clk or negedge s_rst_n)
    if (!s_rst_n) begin
      busy <= 1'b0; beat <= '0; cur_we <= 1'b0; base <= '0; wsh <= '0; pack <= '0;
    end else if (start) begin
      busy <= 1'b1; beat <= '0; cur_we <= a_out[AW]; base <= a_out[AW-1:0];
      wsh  <= a_out[AW] ? w_out : '0;
    end else if (fire) begin
      wsh  <= wsh >> SW;
      pack <= r_word[MW-1:SW];
      if (beat == LAST) begin
        busy <= 1'b0; beat <= '0;
      end else
        beat <= beat + 1'b1;
    end
endmodule

module xclk_width_bridge_chk #(
  parameter int SW = 8,
  parameter int AW = 16,
  parameter int MW = 32,
  parameter int BW = 2,
  parameter int RATIO = 4
) (
  input logic          m_clk,
  input logic          m_rst_n,
  input logic          s_clk,
  input logic          s_rst_n,
  input logic          m_cmd_ready,
  input logic          m_cmd_we,
  input logic          a_full,
  input logic          w_full,
  input logic          m_rsp_valid,
  input logic          m_rsp_ready,
  input logic [MW-1:0] m_rsp_data,
  input logic          s_valid,
  input logic          s_ready,
  input logic          s_we,
  input logic [AW-1:0] s_addr,
  input logic [SW-1:0] s_wdata,
  input logic [BW-1:0] beat
);
  p_hold_r8: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_valid && !s_ready |=> s_valid && $stable(s_addr) && $stable(s_we) && $stable(s_wdata));

  p_addr_step_r1: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_valid && s_ready && beat != BW'(RATIO-1) |=>
      s_valid && s_addr == $past(s_addr) + AW'(1) && s_we == $past(s_we));

  p_no_overflow_r4: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    a_full |-> !m_cmd_ready);

  p_wr_full_r4: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    m_cmd_we && w_full |-> !m_cmd_ready);

  p_rsp_stable_r5: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    m_rsp_valid && !m_rsp_ready |=> m_rsp_valid && $stable(m_rsp_data));
endmodule

bind xclk_width_bridge xclk_width_bridge_chk #(.SW(SW), .AW(AW), .MW(MW), .BW(BW), .RATIO(RATIO)) u_chk (
  .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
  .m_cmd_ready(m_cmd_ready), .m_cmd_we(m_cmd_we), .a_full(a_full), .w_full(w_full),
  .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready), .m_rsp_data(m_rsp_data),
  .s_valid(s_valid), .s_ready(s_ready), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
  .beat(beat));

// File: tb/xclk_width_bridge_bench.sv
`timescale 1ns/1ps
module xclk_width_bridge_bench;
  localparam int MW = 32, SW = 8, AW = 16, RATIO = MW / SW, DEPTH = 4;

  logic m_clk = 0, s_clk = 0, m_rst_n = 0, s_rst_n = 0;
  logic m_cmd_valid = 0, m_cmd_we = 0, m_rsp_ready = 0, s_ready = 0;
  logic [AW-1:0] m_cmd_addr = '0;
  logic [MW-1:0] m_cmd_wdata = '0;
  logic m_cmd_ready, m_rsp_valid, s_valid, s_we;
  logic [MW-1:0] m_rsp_data;
  logic [AW-1:0] s_addr;
  logic [SW-1:0] s_wdata, s_rdata;

  realtime s_half = 20.0;
  int nvec = 0, nmis = 0, stall_s = 0, stall_m = 0;
  bit s_block = 0, wd = 0;

  typedef struct packed { logic we; logic [AW-1:0] a; logic [SW-1:0] d; } beat_t;
  beat_t sq[$];
  logic [MW-1:0] rq[$];

  always #5 m_clk = ~m_clk;
  initial forever #(s_half) s_clk = ~s_clk;

  function automatic logic [SW-1:0] rd_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction
  assign s_rdata = rd_byte(s_addr);

  xclk_width_bridge #(.MW(MW), .SW(SW), .AW(AW), .DEPTH_LOG2(2)) u_xclk_width_bridge (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // slave stub and beat monitor (R1, R2 addresses, R3 order)
  always @(negedge s_clk) begin
    beat_t e;
    if (!s_rst_n) s_ready = 0;
    else begin
      s_ready = !s_block && ($urandom_range(99) >= stall_s);
      if (s_valid && s_ready) begin
        if (sq.size() == 0) chk(0, "R9", "unexpected slave beat", {s_we, s_addr}, 0);
        else begin
          e = sq.pop_front();
          if (e.we) chk({s_we, s_addr, s_wdata} == e, "R1", "write beat", {s_we, s_addr, s_wdata}, e);
          else      chk({s_we, s_addr} == {e.we, e.a}, "R2", "read beat", {s_we, s_addr}, {e.we, e.a});
        end
      end
    end
  end

  // response monitor (R2 packing, R3 order, R5 no spurious response)
  always @(negedge m_clk) begin
    if (!m_rst_n) m_rsp_ready = 0;
    else begin
      m_rsp_ready = ($urandom_range(99) >= stall_m);
      if (m_rsp_valid && m_rsp_ready) begin
        if (rq.size() == 0) chk(0, "R5", "spurious response", m_rsp_data, 0);
        else begin
          logic [MW-1:0] x;
          x = rq.pop_front();
          chk(m_rsp_data == x, "R2", "packed read word", m_rsp_data, x);
        end
      end
    end
  end

  task automatic push_exp(input bit we, input logic [AW-1:0] a, input logic [MW-1:0] d);
    logic [MW-1:0] w;
    for (int i = 0; i < RATIO; i++) begin
      sq.push_back({we, AW'(a + i), we ? d[i*SW +: SW] : {SW{1'b0}}});
      w[i*SW +: SW] = rd_byte(AW'(a + i));
    end
    if (!we) rq.push_back(w);
  endtask

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [MW-1:0] d);
    @(negedge m_clk);
    m_cmd_valid = 1; m_cmd_we = we; m_cmd_addr = a; m_cmd_wdata = d;
    #1;
    while (!m_cmd_ready) begin @(negedge m_clk); #1; end
    push_exp(we, a, d);
    @(negedge m_clk);
    m_cmd_valid = 0;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 20000 && (sq.size() != 0 || rq.size() != 0); k++) @(negedge m_clk);
    chk(sq.size() == 0 && rq.size() == 0, req, "all expected items seen", {sq.size(), rq.size()}, 0);
  endtask

  task automatic mixed(input int n);
    for (int c = 0; c < n; c++)
      issue($urandom_range(1), AW'($urandom), {$urandom});
  endtask

  task automatic run();
    int got;
    #100; m_rst_n = 1; s_rst_n = 1;
    @(negedge m_clk); #1;
    chk(m_cmd_ready == 1, "R6", "ready after reset", m_cmd_ready, 1);
    chk(m_rsp_valid == 0, "R6", "rsp valid after reset", m_rsp_valid, 0);
    chk(s_valid == 0, "R6", "slave valid after reset", s_valid, 0);

    // directed write and read, no stalls, slow slave (R1, R2, R7)
    issue(1, 16'h0100, 32'hA1B2C3D4);
    issue(0, 16'h0200, '0);
    issue(1, 16'hFFFE, 32'h01020304);
    drain("R7");

    // slow slave with random stalls both sides (R7, R9)
    stall_s = 30; stall_m = 30;
    mixed(30);
    drain("R9");

    // capacity with slave port stalled (R4)
    s_block = 1; got = 0;
    for (int c = 0; c < 150; c++) begin
      @(negedge m_clk);
      m_cmd_valid = 1; m_cmd_we = 1; m_cmd_addr = AW'(16'h3000 + c * 8); m_cmd_wdata = {$urandom};
      #1;
      if (m_cmd_ready) begin push_exp(1, m_cmd_addr, m_cmd_wdata); got++; end
    end
    chk(got == DEPTH + 1, "R4", "writes taken while slave stalled", got, DEPTH + 1);
    chk(m_cmd_ready == 0, "R4", "ready low while full", m_cmd_ready, 0);
    // release while still offering: load meets freed entry
    s_block = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge m_clk);
      m_cmd_valid = 1; m_cmd_we = c[0]; m_cmd_addr = AW'(16'h5000 + c * 8); m_cmd_wdata = {$urandom};
      #1;
      if (m_cmd_ready) push_exp(m_cmd_we, m_cmd_addr, m_cmd_wdata);
    end
    @(negedge m_clk); m_cmd_valid = 0;
    drain("R4");

    // fast slave (4x master) with random stalls (R7, R9)
    s_half = 1.25;
    mixed(40);
    drain("R7");
    stall_s = 0; stall_m = 60;
    for (int c = 0; c < 12; c++) issue(0, AW'(16'h7000 + c * 4), '0);
    drain("R3");

    // idle: requests with nothing queued (R5)
    stall_m = 0;
    repeat (50) @(negedge m_clk);
    #1;
    chk(m_rsp_valid == 0, "R5", "no response when empty", m_rsp_valid, 0);
    chk(s_valid == 0 && sq.size() == 0, "R9", "slave idle, nothing extra", s_valid, 0);
  endtask

  initial begin
    fork
      run();
      begin #1500000; wd = 1; end
    join_any
    disable fork;
    if (wd) chk(0, "R9", "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule